// File: doc/BRIEF.md
# Memory ECC Encoder and Checker with Partial-Write Merge

This block guards a 32-bit memory word with an 8-bit check byte kept in a fifth byte lane. A full-word write is passed to memory in the cycle it is accepted, together with its freshly computed check byte. A read returns the word after the block recomputes the syndrome. Any single flipped bit, whether in data or in the check byte, is repaired on the way out. Two flipped bits are flagged as uncorrectable. Any 3- or 4-bit damage confined to one aligned nibble is also flagged as uncorrectable.

A write whose byte enables are not all set becomes a read-modify-write. The block reads the stored word and corrects it. It then overlays the enabled bytes, encodes the result and writes it back. If the read half finds uncorrectable damage, the write-back is dropped and the damage is reported. Each decode that finds damage produces a one-cycle pulse and records the syndrome. It also bumps one of two saturating event counters. The memory behind the block is a plain synchronous array with one cycle of read latency.

Top module: `ecc_mem_guard`

## Requirements
- R1: A word stored by a full write (all four enables set) reads back unchanged, with neither error pulse.
- R2: Flipping any one of the 40 stored bits yields the original word on read, with err_single high for exactly the response cycle and err_uncorr low; the 40 cases give 40 distinct syndromes.
- R3: Flipping any two of the 40 stored bits raises err_uncorr and not err_single.
- R4: Any 3- or 4-bit pattern within one aligned nibble raises err_uncorr and not err_single. The ten nibbles are data bits [4k+3:4k] for k=0..7, plus check-byte bits [3:0] and [7:4].
- R5: A write with some enables clear replaces only the bytes whose enable is set (enable bit b covers data bits [8b+7:8b]) and keeps the other bytes.
- R6: A partial write whose read finds one flipped bit reports err_single and writes back the corrected, merged word, so the next read of that word is clean.
- R7: A partial write whose read finds uncorrectable damage reports err_uncorr and leaves the stored data and check byte untouched.
- R8: err_syndrome is zero after reset, takes a nonzero value in the cycle of each error pulse, and holds that value through clean accesses.
- R9: cnt_corr and cnt_uncorr count err_single and err_uncorr pulses in the same cycle as the pulse, stop at all ones, and read zero after reset and after a one-cycle clr_cnt.
- R10: After reset req_ready is high and rsp_valid low. A read or partial write accepted at one clock edge drops req_ready for the next cycle. rsp_valid is high for one cycle, following the second clock edge after the read was accepted, and the error pulses for any operation appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte enables for writes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Corrected read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data to memory |
| mem_wcheck | output | CHK_W | Check byte to memory |
| mem_rdata | input | DATA_W | Data from memory, one cycle after a read strobe |
| mem_rcheck | input | CHK_W | Check byte from memory |
| err_single | output | 1 | Corrected-error pulse |
| err_uncorr | output | 1 | Uncorrectable-error pulse |
| err_syndrome | output | CHK_W | Syndrome of the latest error |
| clr_cnt | input | 1 | Clears both counters |
| cnt_corr | output | CNT_W | Saturating corrected-event count |
| cnt_uncorr | output | CNT_W | Saturating uncorrectable-event count |

## Verification
Suppose a wrong check column or a wrong check-bit permutation were built in. A clean read would still pass. The fault would appear on the first read after an injected flip: a wrong correction flag, a changed data word, or two bit positions sharing a syndrome. Nibble sweeps over all ten nibbles, including both check-byte nibbles, show up any pattern that aliases to a single-bit column. A wrong merge or a missed write-back suppression shows up either on the memory array right after the partial write or on the next read of that word. A counter slip is visible in the very cycle of the pulse.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

   localparam int WORD_W = 32;
   localparam int CHECK_W = 8;

   typedef logic [WORD_W-1:0]  word_t;
   typedef logic [CHECK_W-1:0] chk_t;

   // Storage position j of the check byte carries syndrome bit map_pos(j).
   // Chosen so that no three bits of either stored check nibble equal a data column.
   function automatic int map_pos(input int j);
      case (j)
         0: return 0;
         1: return 2;
         2: return 5;
         3: return 7;
         4: return 1;
         5: return 3;
         6: return 4;
         default: return 6;
      endcase
   endfunction

   // Weight-3 data columns: each nibble shares one bit pair, third bit differs.
   function automatic chk_t data_col(input int i);
      case (i)
         0: return 8'h07;  1: return 8'h0B;  2: return 8'h43;  3: return 8'h83;
         4: return 8'h0D;  5: return 8'h0E;  6: return 8'h1C;  7: return 8'h2C;
         8: return 8'h34;  9: return 8'h38; 10: return 8'h70; 11: return 8'hB0;
        12: return 8'hC1; 13: return 8'hC2; 14: return 8'hD0; 15: return 8'hE0;
        16: return 8'h15; 17: return 8'h19; 18: return 8'h51; 19: return 8'h91;
        20: return 8'h26; 21: return 8'h2A; 22: return 8'h62; 23: return 8'hA2;
        24: return 8'h45; 25: return 8'h46; 26: return 8'h54; 27: return 8'h64;
        28: return 8'h89; 29: return 8'h8A; 30: return 8'h98; default: return 8'hA8;
      endcase
   endfunction

   function automatic chk_t word_parity(input word_t d);
      chk_t p = '0;
      for (int i = 0; i < WORD_W; i++)
         if (d[i]) p ^= data_col(i);
      return p;
   endfunction

   function automatic chk_t to_store(input chk_t p);
      chk_t c;
      for (int j = 0; j < CHECK_W; j++) c[j] = p[map_pos(j)];
      return c;
   endfunction

   function automatic chk_t from_store(input chk_t c);
      chk_t p;
      for (int j = 0; j < CHECK_W; j++) p[map_pos(j)] = c[j];
      return p;
   endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
   import ecc_guard_pkg::*;
(
   input  word_t data_i,
   output chk_t  check_o
);
   assign check_o = to_store(word_parity(data_i));
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
   import ecc_guard_pkg::*;
(
   input  word_t data_i,
   input  chk_t  check_i,
   output chk_t  syndrome_o,
   output word_t fixed_o,
   output logic  single_o,
   output logic  uncorr_o
);
   chk_t  syn;
   word_t hit;

   assign syn = word_parity(data_i) ^ from_store(check_i);

   for (genvar i = 0; i < WORD_W; i++) begin : g_col
      assign hit[i] = (syn == data_col(i));
   end

   assign syndrome_o = syn;
   assign fixed_o    = data_i ^ hit;
   assign single_o   = (|hit) | $onehot(syn);
   assign uncorr_o   = (|syn) & ~single_o;
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (clr)                  count <= '0;
      else if (inc && count != TOP)  count <= count + 1'b1;
   end

   // R9
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP && !clr) |=> count == TOP);

   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
endmodule

// File: rtl/ecc_mem_guard.sv
module ecc_mem_guard
   import ecc_guard_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int CHK_W  = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [CHK_W-1:0]  mem_wcheck,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W-1:0]  mem_rcheck,
   output logic              err_single,
   output logic              err_uncorr,
   output logic [CHK_W-1:0]  err_syndrome,
   input  logic              clr_cnt,
   output logic [CNT_W-1:0]  cnt_corr,
   output logic [CNT_W-1:0]  cnt_uncorr
);
   localparam int BE_W   = DATA_W / 8;
   localparam int N_CNT  = 2;

   if (DATA_W != WORD_W) begin : g_bad_data
      $error("ecc_mem_guard: code is defined for a 32-bit word only");
   end
   if (CHK_W != CHECK_W) begin : g_bad_chk
      $error("ecc_mem_guard: code needs exactly 8 check bits");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ecc_mem_guard: counter width must be positive");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MERGE} st_t;

   st_t               state;
   logic [ADDR_W-1:0] hold_addr;
   logic [BE_W-1:0]   hold_be;
   word_t             hold_wdata;

   logic  accept, full_wr, dec_live;
   word_t fixed, merged, enc_in;
   chk_t  enc_out, syn;
   logic  dec_single, dec_uncorr;
   logic [N_CNT-1:0] ev;
   logic [CNT_W-1:0] cnt [N_CNT];

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign full_wr   = &req_be;
   assign dec_live  = (state != ST_IDLE);

   ecc_syndrome_fix u_fix (
      .data_i     (mem_rdata),
      .check_i    (mem_rcheck),
      .syndrome_o (syn),
      .fixed_o    (fixed),
      .single_o   (dec_single),
      .uncorr_o   (dec_uncorr)
   );

   for (genvar b = 0; b < BE_W; b++) begin : g_merge
      assign merged[8*b +: 8] = hold_be[b] ? hold_wdata[8*b +: 8] : fixed[8*b +: 8];
   end

   assign enc_in = (state == ST_MERGE) ? merged : req_wdata;

   ecc_check_gen u_gen (
      .data_i  (enc_in),
      .check_o (enc_out)
   );

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = req_addr;
      mem_wdata = enc_in;
      mem_wcheck = enc_out;
      if (state == ST_MERGE) begin
         mem_addr = hold_addr;
         mem_en   = !dec_uncorr;
         mem_we   = !dec_uncorr;
      end else if (accept) begin
         mem_en = 1'b1;
         mem_we = req_we && full_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         hold_addr    <= '0;
         hold_be      <= '0;
         hold_wdata   <= '0;
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         err_single   <= 1'b0;
         err_uncorr   <= 1'b0;
         err_syndrome <= '0;
      end else begin
         rsp_valid  <= (state == ST_READ);
         err_single <= dec_live && dec_single;
         err_uncorr <= dec_live && dec_uncorr;
         if (state == ST_READ) rsp_rdata <= fixed;
         if (dec_live && (|syn)) err_syndrome <= syn;
         case (state)
            ST_IDLE: if (accept && !(req_we && full_wr)) begin
               hold_addr  <= req_addr;
               hold_be    <= req_be;
               hold_wdata <= req_wdata;
               state      <= req_we ? ST_MERGE : ST_READ;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ev[0] = dec_live && dec_single;
   assign ev[1] = dec_live && dec_uncorr;

   for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
      ecc_sat_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr_cnt),
         .inc   (ev[k]),
         .count (cnt[k])
      );
   end

   assign cnt_corr   = cnt[0];
   assign cnt_uncorr = cnt[1];

   // R2
   one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_single && err_uncorr));

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_single |=> !err_single);

   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R10
   busy_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_we) |=> !req_ready);

   // R7
   no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_uncorr |-> !$past(mem_we));

   // R8
   syn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_single && !err_uncorr) |-> $stable(err_syndrome));

   // R8
   syn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_single || err_uncorr) |-> err_syndrome != '0);
endmodule

// File: tb/ecc_mem_guard_tb.sv
module ecc_mem_guard_tb;
   localparam int AW = 6;
   localparam int CW = 4;
   localparam int DEPTH = 1 << AW;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_we = 0, clr_cnt = 0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0] req_be = '0;
   logic [31:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_en, mem_we, err_single, err_uncorr;
   logic [31:0] rsp_rdata, mem_wdata, rd_d;
   logic [7:0] mem_wcheck, rd_c, err_syndrome;
   logic [AW-1:0] mem_addr;
   logic [CW-1:0] cnt_corr, cnt_uncorr;

   logic inj_en = 0;
   logic [AW-1:0] inj_addr = '0;
   logic [39:0] inj_mask = '0;
   logic [31:0] md [DEPTH];
   logic [7:0]  mc [DEPTH];

   always #4 clk = ~clk;

   ecc_mem_guard #(.ADDR_W(AW), .DATA_W(32), .CHK_W(8), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wcheck(mem_wcheck),
      .mem_rdata(rd_d), .mem_rcheck(rd_c), .err_single(err_single),
      .err_uncorr(err_uncorr), .err_syndrome(err_syndrome), .clr_cnt(clr_cnt),
      .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr));

   always @(posedge clk) begin
      if (inj_en) begin
         md[inj_addr] <= md[inj_addr] ^ inj_mask[31:0];
         mc[inj_addr] <= mc[inj_addr] ^ inj_mask[39:32];
      end else if (mem_en) begin
         if (mem_we) begin
            md[mem_addr] <= mem_wdata;
            mc[mem_addr] <= mem_wcheck;
         end else begin
            rd_d <= md[mem_addr];
            rd_c <= mc[mem_addr];
         end
      end
   end

   int n_chk = 0, n_bad = 0;
   int exp_cc = 0, exp_cu = 0;
   logic [7:0] last_syn = '0;
   logic [31:0] gold [DEPTH];
   logic [39:0] ginj [DEPTH];
   logic r_ready1, r_rsp1, c_rsp, c_s, c_u;
   logic [31:0] c_data;
   logic [7:0] c_syn;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
      return r;
   endfunction

   task automatic op(input bit we, input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 0;
      r_ready1 = req_ready; r_rsp1 = rsp_valid;
      @(negedge clk);
      c_rsp = rsp_valid; c_data = rsp_rdata; c_s = err_single; c_u = err_uncorr; c_syn = err_syndrome;
   endtask

   task automatic post(input bit es, input bit eu, input string tag);
      chk(c_s == es && c_u == eu, tag, {c_s, c_u}, {es, eu});
      if (es && exp_cc < MAXC) exp_cc++;
      if (eu && exp_cu < MAXC) exp_cu++;
      chk(cnt_corr == exp_cc[CW-1:0] && cnt_uncorr == exp_cu[CW-1:0], "R9",
          {cnt_corr, cnt_uncorr}, {exp_cc[CW-1:0], exp_cu[CW-1:0]});
      if (es || eu) begin
         chk(c_syn != 0, "R8", c_syn, 1);
         last_syn = c_syn;
      end else chk(c_syn == last_syn, "R8", c_syn, last_syn);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string tag);
      int w = $countones(ginj[a]);
      bit es = (w == 1), eu = (w >= 2);
      op(0, a, 0, 0);
      chk(!r_ready1 && !r_rsp1, "R10", {r_ready1, r_rsp1}, 0);
      chk(c_rsp == 1, "R10", c_rsp, 1);
      if (!eu) chk(c_data == gold[a], tag, c_data, gold[a]);
      post(es, eu, tag);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
      int w = $countones(ginj[a]);
      bit full = &be;
      bit es = !full && (w == 1), eu = !full && (w >= 2);
      logic [39:0] snap = {mc[a], md[a]};
      op(1, a, d, be);
      chk(r_ready1 == full, "R10", r_ready1, full);
      chk(c_rsp == 0, "R10", c_rsp, 0);
      post(es, eu, full ? "R1" : (eu ? "R7" : (es ? "R6" : "R5")));
      if (eu) chk({mc[a], md[a]} == snap, "R7", {mc[a], md[a]}, snap);
      else begin
         gold[a] = full ? d : merge(gold[a], d, be);
         ginj[a] = '0;
      end
   endtask

   task automatic inject(input logic [AW-1:0] a, input logic [39:0] m);
      @(negedge clk);
      inj_en = 1; inj_addr = a; inj_mask = m;
      @(negedge clk);
      inj_en = 0;
      ginj[a] ^= m;
   endtask

   task automatic clear_counts();
      @(negedge clk); clr_cnt = 1;
      @(negedge clk); clr_cnt = 0;
      exp_cc = 0; exp_cu = 0;
      chk(cnt_corr == 0 && cnt_uncorr == 0, "R9", {cnt_corr, cnt_uncorr}, 0);
   endtask

   function automatic logic [39:0] nib_mask(input int k, input logic [3:0] p);
      return {36'd0, p} << (4 * k);
   endfunction

   initial begin
      logic [7:0] syns [40];
      logic [3:0] pats [5];
      pats[0] = 4'h7; pats[1] = 4'hB; pats[2] = 4'hD; pats[3] = 4'hE; pats[4] = 4'hF;
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      chk(req_ready == 1 && rsp_valid == 0, "R10", {req_ready, rsp_valid}, 2'b10);
      chk(cnt_corr == 0 && cnt_uncorr == 0, "R9", {cnt_corr, cnt_uncorr}, 0);
      chk(err_syndrome == 0 && !err_single && !err_uncorr, "R8", err_syndrome, 0);
      rst_n = 1;

      for (int a = 0; a < DEPTH; a++) begin
         gold[a] = '0; ginj[a] = '0;
         do_write(a[AW-1:0], $urandom, 4'hF);
      end
      do_write(1, 32'h0, 4'hF);
      do_write(2, 32'hFFFF_FFFF, 4'hF);
      for (int a = 0; a < 8; a++) do_read(a[AW-1:0], "R1");

      // R2: every single position, counters run into saturation
      clear_counts();
      for (int b = 0; b < 40; b++) begin
         inject(5, 40'd1 << b);
         do_read(5, "R2");
         syns[b] = c_syn;
         inject(5, 40'd1 << b);
      end
      chk(cnt_corr == MAXC[CW-1:0], "R9", cnt_corr, MAXC);
      for (int i = 0; i < 40; i++)
         for (int j = i + 1; j < 40; j++)
            chk(syns[i] != syns[j], "R2", syns[i], syns[j]);
      do_read(5, "R1");

      // R3: pairs, including data/check mixes
      for (int t = 0; t < 40; t++) begin
         int x = t;
         int y = (t + 1 + ($urandom % 39)) % 40;
         logic [39:0] m = (40'd1 << x) | (40'd1 << y);
         inject(9, m);
         do_read(9, "R3");
         inject(9, m);
      end

      // R4: every nibble, every 3- and 4-bit pattern
      for (int k = 0; k < 10; k++)
         for (int p = 0; p < 5; p++) begin
            inject(12, nib_mask(k, pats[p]));
            do_read(12, "R4");
            inject(12, nib_mask(k, pats[p]));
         end

      clear_counts();

      // R5: partial writes on clean words
      do_write(20, 32'hA5A5_A5A5, 4'b0001); do_read(20, "R5");
      do_write(20, 32'h1234_5678, 4'b0110); do_read(20, "R5");
      do_write(20, 32'hDEAD_BEEF, 4'b1000); do_read(20, "R5");
      do_write(21, 32'hCAFE_F00D, 4'b0000); do_read(21, "R5");

      // R6: partial write over a single flip
      inject(22, 40'd1 << 37);
      do_write(22, 32'h0000_5500, 4'b0010); do_read(22, "R6");
      inject(23, 40'd1 << 3);
      do_write(23, 32'h7700_0000, 4'b1000); do_read(23, "R6");

      // R7: partial write over a double flip, then a nibble pattern
      inject(24, 40'h00_0000_0101);
      do_write(24, 32'h1111_1111, 4'b0001);
      do_read(24, "R7");
      do_write(24, 32'h2222_2222, 4'hF); do_read(24, "R1");
      inject(25, nib_mask(9, 4'hE));
      do_write(25, 32'h3333_3333, 4'b0100);
      do_write(25, 32'h4444_4444, 4'hF); do_read(25, "R1");

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         int r = $urandom % 10;
         logic [AW-1:0] a = AW'($urandom % DEPTH);
         if (r < 2) do_write(a, $urandom, 4'hF);
         else if (r < 4) do_write(a, $urandom, 4'($urandom % 15));
         else if (r < 8) do_read(a, "R2");
         else if (ginj[a] == 0) begin
            int kind = $urandom % 3;
            if (kind == 0) inject(a, 40'd1 << ($urandom % 40));
            else if (kind == 1) begin
               int x = $urandom % 40;
               int y = (x + 1 + ($urandom % 39)) % 40;
               inject(a, (40'd1 << x) | (40'd1 << y));
            end else inject(a, nib_mask($urandom % 10, pats[$urandom % 5]));
            do_read(a, "R4");
         end
         if (n == 300) clear_counts();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule